// File: doc/BRIEF.md
# Gate Pulse Modulator Sequencer

This block is the digital core of a three-way gate-voltage multiplexer for a display panel. It decides, each clock cycle, whether the panel's gate-drive output is tied to ground, connected to the high gate rail, or moved onto the slewing path toward the low reference. It can also leave the output undriven. All inputs are synchronous flags: the control pulse from the timing controller, a main enable, a supply-undervoltage flag, a supply-monitor "good" flag, a comparator that reports the high rail is still above 3 V, and a strap that selects zero delay.

Two cycle counters replace external timing capacitors. A power-on counter measures how long the supply has been out of undervoltage before the sequencer may enable. A falling-edge counter sets the pause between the control pulse going low and the start of the low slew. A rising control pulse switches the output high at once. During power-down the output is held on the high rail while that rail lasts. Once the rail collapses, the output floats until the supply is good again. The three selects are registered. A change from one driven state to another always passes through one all-off cycle, so two switches are never closed together.

Top module: `gpm_sequencer`

## Requirements
- R1: While `rstN` is low, the output is ground (`{selGnd,selHigh,selSlew}` = 100). The power-on and falling-edge counters are cleared.
- R2: When the block is not enabled and not in a power-down override, the output settles to ground. This includes the case where supply loss is seen before the block was ever enabled.
- R3: The block becomes enabled only when `enReady` and `monOk` are high and `uvFlag` has been low for at least `powerOnCfg` cycles. With `uvFlag` dropped at sample n=0 and the control pulse high, the output is ground through n=P, all-off at n=P+1 and high rail at n=P+2.
- R4: When enabled with the control pulse high, the output selects the high rail (010).
- R5: After the control pulse falls with the strap low, the output stays high for `delayCfg` = D cycles. It is all-off at n=D+1 and slewing (001) from n=D+2 on.
- R6: With `zeroDelay` high, the low transition starts in the same cycle the falling pulse is sampled: all-off at n=1 and slewing at n=2, whatever D is.
- R7: A rising control pulse switches toward the high rail with no programmed delay. A rise during the falling-edge delay cancels that delay, the output stays high, and the counter restarts from zero on the next fall.
- R8: Once the block has been enabled, if `uvFlag` goes high or `monOk` goes low while `railUp` is high, the output is forced to the high rail.
- R9: If that power-down condition holds while `railUp` is low, all selects go off (000) and stay off until `uvFlag` is low and `monOk` is high. The block then returns to ground and repeats the power-on delay.
- R10: At most one select is high in any cycle. Two different driven selects are always separated by at least one all-off cycle.
- R11: `delayCfg` and `powerOnCfg` are captured only while `rstN` is low. Changing them afterwards has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; configuration is captured while low |
| delayCfg | input | DLY_W | Falling-edge delay in cycles |
| powerOnCfg | input | PON_W | Power-on enable delay in cycles |
| pulseIn | input | 1 | Control pulse from the timing controller |
| enReady | input | 1 | Main enable |
| uvFlag | input | 1 | Supply undervoltage, high = undervoltage |
| monOk | input | 1 | Supply monitor, high = supply good |
| railUp | input | 1 | High gate rail above 3 V |
| zeroDelay | input | 1 | Zero-delay strap |
| selGnd | output | 1 | Output switch to ground |
| selHigh | output | 1 | Output switch to high rail |
| selSlew | output | 1 | Output switch to low-reference slew path |

## Verification
The hardest state to reach is the collapse float. To get there, the block must first be enabled and armed. It must then leave a slewing output, pass through the high-rail override, and finally see the rail comparator drop while the supply is still in undervoltage. The bench walks this chain in order and counts each break-before-make gap. It then releases undervoltage and checks for the return to ground and a fresh power-on delay. The falling-edge delay is swept over several lengths, with the strap both clear and set, so that the arithmetic edge timing is checked at every boundary.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_GND  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_SLEW = 2'd3
  } gpm_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic dlyClr;   // clear falling-edge delay counter
    logic ponClr;   // clear power-on counter
  } gpm_strobe_t;

endpackage

// File: rtl/gpm_dpath.sv
module gpm_dpath
  import gpm_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int PON_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DLY_W-1:0] delayCfg,
  input  logic [PON_W-1:0] powerOnCfg,
  input  gpm_strobe_t      strb,
  output logic             dlyDone,
  output logic             ponDone
);

  logic [DLY_W-1:0] dlyLim;
  logic [PON_W-1:0] ponLim;
  logic [DLY_W-1:0] dlyCnt;
  logic [PON_W-1:0] ponCnt;

  // configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyLim <= delayCfg;
      ponLim <= powerOnCfg;
    end
  end

  // falling-edge delay counter, saturating at its limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dlyCnt <= '0;
    else if (strb.dlyClr)     dlyCnt <= '0;
    else if (dlyCnt != dlyLim) dlyCnt <= dlyCnt + 1'b1;
  end

  // power-on counter, saturating at its limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ponCnt <= '0;
    else if (strb.ponClr)     ponCnt <= '0;
    else if (ponCnt != ponLim) ponCnt <= ponCnt + 1'b1;
  end

  assign dlyDone = (dlyCnt == dlyLim);
  assign ponDone = (ponCnt == ponLim);

  AST_DLY_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.dlyClr |=> dlyCnt == '0) else $error("delay counter not cleared"); // R7

  AST_PON_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ponCnt <= ponLim) else $error("power-on counter overran"); // R3

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(dlyLim) && $stable(ponLim))) else $error("config moved"); // R11

endmodule

// File: rtl/gpm_ctrl.sv
module gpm_ctrl
  import gpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pulseIn,
  input  logic        enReady,
  input  logic        uvFlag,
  input  logic        monOk,
  input  logic        railUp,
  input  logic        zeroDelay,
  input  logic        dlyDone,
  input  logic        ponDone,
  output gpm_strobe_t strb,
  output gpm_sel_e    curSel
);

  logic     supplyDown;
  logic     enabled;
  logic     armed;
  logic     collapsed;
  logic     setCollapse;
  gpm_sel_e target;

  assign supplyDown = uvFlag | ~monOk;
  assign enabled    = ponDone & enReady & ~supplyDown;

  // target select, highest priority first
  always_comb begin
    setCollapse = 1'b0;
    if (collapsed) begin
      target = SEL_NONE;
    end else if (supplyDown && armed) begin
      if (railUp) begin
        target = SEL_HIGH;
      end else begin
        target      = SEL_NONE;
        setCollapse = 1'b1;
      end
    end else if (!enabled) begin
      target = SEL_GND;
    end else if (pulseIn) begin
      target = SEL_HIGH;
    end else if (zeroDelay || dlyDone) begin
      target = SEL_SLEW;
    end else begin
      target = SEL_HIGH;
    end
  end

  always_comb begin
    strb.dlyClr = pulseIn | ~enabled | collapsed;
    strb.ponClr = uvFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            collapsed <= 1'b0;
    else if (setCollapse) collapsed <= 1'b1;
    else if (!supplyDown) collapsed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        armed <= 1'b0;
    else if (setCollapse || !enReady) armed <= 1'b0;
    else if (enabled)                 armed <= 1'b1;
  end

  // registered select with one all-off cycle between driven states
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    curSel <= SEL_GND;
    else if (target == curSel)    curSel <= curSel;
    else if (curSel == SEL_NONE)  curSel <= target;
    else                          curSel <= SEL_NONE;
  end

  AST_BBM_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (curSel != SEL_NONE && $past(curSel) != SEL_NONE) |-> curSel == $past(curSel))
    else $error("drives adjacent without gap"); // R10

  AST_COLLAPSE_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    collapsed |=> curSel == SEL_NONE) else $error("collapse not floating"); // R9

  AST_IDLE_GND: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !armed && !collapsed) |=> (curSel == SEL_GND || curSel == SEL_NONE))
    else $error("idle not heading to ground"); // R2

  AST_OVERRIDE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (supplyDown && armed && railUp && !collapsed) |=> (curSel == SEL_HIGH || curSel == SEL_NONE))
    else $error("override not heading high"); // R8

  AST_PULSE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && pulseIn && !collapsed) |=> (curSel == SEL_HIGH || curSel == SEL_NONE))
    else $error("pulse high not heading high"); // R4

endmodule

// File: rtl/gpm_sequencer.sv
module gpm_sequencer
  import gpm_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int PON_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DLY_W-1:0] delayCfg,
  input  logic [PON_W-1:0] powerOnCfg,
  input  logic             pulseIn,
  input  logic             enReady,
  input  logic             uvFlag,
  input  logic             monOk,
  input  logic             railUp,
  input  logic             zeroDelay,
  output logic             selGnd,
  output logic             selHigh,
  output logic             selSlew
);

  gpm_strobe_t strb;
  gpm_sel_e    curSel;
  logic        dlyDone;
  logic        ponDone;

  gpm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pulseIn   (pulseIn),
    .enReady   (enReady),
    .uvFlag    (uvFlag),
    .monOk     (monOk),
    .railUp    (railUp),
    .zeroDelay (zeroDelay),
    .dlyDone   (dlyDone),
    .ponDone   (ponDone),
    .strb      (strb),
    .curSel    (curSel)
  );

  gpm_dpath #(.DLY_W(DLY_W), .PON_W(PON_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .delayCfg   (delayCfg),
    .powerOnCfg (powerOnCfg),
    .strb       (strb),
    .dlyDone    (dlyDone),
    .ponDone    (ponDone)
  );

  assign selGnd  = (curSel == SEL_GND);
  assign selHigh = (curSel == SEL_HIGH);
  assign selSlew = (curSel == SEL_SLEW);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $countones({selGnd, selHigh, selSlew}) <= 1) else $error("multiple selects"); // R10

endmodule

// File: tb/gpm_sequencer_bench.sv
module gpm_sequencer_bench;
  localparam int DW = 16;
  localparam int PW = 20;
  localparam logic [2:0] GND = 3'b100, HIGH = 3'b010, SLEW = 3'b001, NONE = 3'b000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, pulseIn, enReady, uvFlag, monOk, railUp, zeroDelay;
  logic [DW-1:0] delayCfg;
  logic [PW-1:0] powerOnCfg;
  logic selGnd, selHigh, selSlew;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  gpm_sequencer u_gpm_sequencer (
    .clk(clk), .rstN(rstN), .delayCfg(delayCfg), .powerOnCfg(powerOnCfg),
    .pulseIn(pulseIn), .enReady(enReady), .uvFlag(uvFlag), .monOk(monOk),
    .railUp(railUp), .zeroDelay(zeroDelay),
    .selGnd(selGnd), .selHigh(selHigh), .selSlew(selSlew)
  );

  task automatic chk(input logic [2:0] exp, input string req);
    total++;
    if ({selGnd, selHigh, selSlew} !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b at %0t", req, {selGnd, selHigh, selSlew}, exp, $time);
    end
  endtask

  // reset with given config; configs are scrambled after release (R11)
  task automatic doReset(input int p, input int d);
    rstN = 1'b0; powerOnCfg = PW'(p); delayCfg = DW'(d);
    uvFlag = 1'b1; monOk = 1'b1; railUp = 1'b0; enReady = 1'b1;
    pulseIn = 1'b1; zeroDelay = 1'b0;
    repeat (3) @(negedge clk);
    chk(GND, "R1 reset");
    rstN = 1'b1;
    delayCfg = '1; powerOnCfg = '1;
  endtask

  // drop undervoltage and walk the power-on delay (R3, R11)
  task automatic powerUp(input int p, input bit fromNone);
    uvFlag = 1'b0; railUp = 1'b1;
    for (int n = 1; n <= p + 2; n++) begin
      @(negedge clk);
      if (n <= p) chk((fromNone && n == 1) ? NONE : GND, "R3 R11 pre-enable");
      else if (n == p + 1) chk(NONE, "R3 R10 gap");
      else chk(HIGH, "R3 R4 enabled high");
    end
  endtask

  // falling pulse with delay d (R5, R6, R10, R11)
  task automatic fall(input int d, input bit z);
    int last;
    last = (d + 2 > 3) ? d + 2 : 3;
    pulseIn = 1'b0;
    for (int n = 1; n <= last; n++) begin
      @(negedge clk);
      if (z) chk(n == 1 ? NONE : SLEW, "R6 zero delay");
      else if (n <= d) chk(HIGH, "R5 R11 delay hold");
      else if (n == d + 1) chk(NONE, "R5 R10 gap");
      else chk(SLEW, "R5 slew");
    end
  endtask

  task automatic rise();
    pulseIn = 1'b1;
    @(negedge clk); chk(NONE, "R7 R10 rise gap");
    @(negedge clk); chk(HIGH, "R7 rise high");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog all got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    @(negedge clk);

    // power-on delay sweep
    for (int p = 0; p <= 3; p++) begin
      doReset(p, 1);
      powerUp(p, 1'b0);
    end

    // supply loss before ever enabled stays ground (R2)
    doReset(2, 1);
    railUp = 1'b1;
    repeat (4) begin @(negedge clk); chk(GND, "R2 unarmed supply loss"); end

    // falling-edge delay sweep, strap clear and set
    for (int d = 0; d <= 6; d++) begin
      for (int z = 0; z <= 1; z++) begin
        doReset(2, d);
        powerUp(2, 1'b0);
        zeroDelay = z[0];
        fall(d, z[0]);
        rise();
      end
    end

    // abort of delay by rising pulse, then fresh delay (R7)
    doReset(2, 5);
    powerUp(2, 1'b0);
    pulseIn = 1'b0;
    repeat (3) begin @(negedge clk); chk(HIGH, "R7 in delay"); end
    pulseIn = 1'b1;
    repeat (8) begin @(negedge clk); chk(HIGH, "R7 abort holds high"); end
    fall(5, 1'b0);

    // enable removal goes to ground (R2)
    enReady = 1'b0;
    @(negedge clk); chk(NONE, "R2 R10 gap");
    @(negedge clk); chk(GND, "R2 disabled ground");
    pulseIn = 1'b1; enReady = 1'b1;
    @(negedge clk); chk(NONE, "R4 R10 gap");
    @(negedge clk); chk(HIGH, "R4 re-enabled high");

    // monitor-low override from slewing, then recovery (R8)
    fall(5, 1'b0);
    monOk = 1'b0;
    @(negedge clk); chk(NONE, "R8 R10 gap");
    repeat (4) begin @(negedge clk); chk(HIGH, "R8 monitor override high"); end
    monOk = 1'b1;
    fall(5, 1'b0);

    // undervoltage override then rail collapse (R8, R9)
    uvFlag = 1'b1;
    @(negedge clk); chk(NONE, "R8 R10 gap");
    repeat (3) begin @(negedge clk); chk(HIGH, "R8 uv override high"); end
    railUp = 1'b0;
    repeat (6) begin @(negedge clk); chk(NONE, "R9 collapsed float"); end
    railUp = 1'b1;
    repeat (3) begin @(negedge clk); chk(NONE, "R9 float despite rail"); end
    pulseIn = 1'b1;
    powerUp(2, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule